// File: doc/BRIEF.md
# Host Nibble-Command Sequencer

This block sits on the host side of a command port that accepts one tagged byte at a time over an 8-bit bus. A request arrives on a simple interface: a valid pulse, a read flag, a 6-bit register address and 8 bits of write data. The sequencer turns it into a series of bytes. Each byte waits for the peripheral's READY handshake before it goes out.

The first byte of every transfer is an address byte. A write then sends its data as two nibble bytes, upper half first. A read sends only the address byte. It then waits for the peripheral's active-low interrupt, pulses a read strobe and captures the bus. Every request ends with a one-cycle done pulse. A read that gets no interrupt within a configurable number of cycles is ended with an error flag instead.

Top module: `nibble_cmd_host`

## Requirements
- R1: `port_sel` is 3'b000 while the sequencer is idle and 3'b100 from the cycle after a request is accepted until the request completes, so it is 3'b100 on every write or read strobe.
- R2: A byte is strobed (`wr_n` low and `bus_oe` high for exactly one cycle) only when `ready_in` was sampled high at the preceding clock edge.
- R3: The first byte of every request is the address byte {1, rd, addr[5:0]}: bit 7 is 1, bit 6 is 1 for a read and 0 for a write, and bits 5:0 are the address.
- R4: A write sends exactly three bytes: the address byte, then {4'b0000, wdata[7:4]}, then {4'b0000, wdata[3:0]}.
- R5: After a strobe, no further byte is sent until `ready_in` has been sampled low and then high again. A READY level that stays high after a strobe is not a new grant.
- R6: For a read, the sequencer waits after the address byte until `int_n` is sampled low. It then drives `rd_n` low for one cycle and captures `bus_in` at the end of that cycle.
- R7: Each request ends with `done` high for exactly one cycle. On that cycle `err` is 0 for a success, and `rdata` holds the captured byte for a read or 0 for a write.
- R8: A request is accepted only while `req_ready` is high (idle). `req_valid` and the request fields are ignored while a request is in progress.
- R9: If `int_n` stays high for TIMEOUT_CYCLES consecutive cycles of the interrupt wait, the read ends with `done` and `err` high, `rdata` 0, and no `rd_n` pulse.
- R10: If `int_n` is first sampled low in the last cycle of the timeout window, the read completes normally with `err` 0.
- R11: During reset the outputs are idle: `wr_n`=1, `rd_n`=1, `bus_oe`=0, `port_sel`=0, `done`=0, `err`=0, `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read timed out (valid with done) |
| rdata | output | 8 | Read data (valid with done) |
| port_sel | output | 3 | Port select toward the peripheral |
| bus_out | output | 8 | Command byte driven onto the bus |
| bus_oe | output | 1 | Bus output enable (high during a strobe) |
| wr_n | output | 1 | Active-low byte write strobe |
| rd_n | output | 1 | Active-low read strobe |
| bus_in | input | 8 | Bus value driven by the peripheral |
| ready_in | input | 1 | Peripheral READY |
| int_n | input | 1 | Peripheral active-low interrupt |

## Verification
Two events can land on the same clock edge: the interrupt arriving and the timeout counter reaching its limit. The bench steps the interrupt delay across the end of the window, one cycle at a time, so that for some delay the interrupt is first seen exactly in the last counted cycle. It expects success there and an error one cycle later. A second overlap, a done pulse and the acceptance of the next request on the same cycle, comes from issuing requests back to back. In both cases a cycle-accurate model in the bench decides the expected strobes, flags and data.

// File: rtl/nibble_cmd_host.sv
module nibble_cmd_host #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_read,
  input  logic [5:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic       done,
  output logic       err,
  output logic [7:0] rdata,
  output logic [2:0] port_sel,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic       wr_n,
  output logic       rd_n,
  input  logic [7:0] bus_in,
  input  logic       ready_in,
  input  logic       int_n
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_WHI, S_STB, S_WLO, S_WINT, S_RD} st_t;

  st_t           st;
  logic          rw_q;
  logic [5:0]    addr_q;
  logic [7:0]    data_q;
  logic [1:0]    idx;
  logic [TW-1:0] tmr;
  logic [7:0]    cur_byte;

  always_comb begin
    case (idx)
      2'd0:    cur_byte = {1'b1, rw_q, addr_q};
      2'd1:    cur_byte = {4'b0000, data_q[7:4]};
      default: cur_byte = {4'b0000, data_q[3:0]};
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign port_sel  = (st == S_IDLE) ? 3'b000 : 3'b100;
  assign bus_oe    = (st == S_STB);
  assign wr_n      = !bus_oe;
  assign bus_out   = bus_oe ? cur_byte : 8'h00;
  assign rd_n      = (st != S_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rw_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      idx    <= '0;
      tmr    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          rw_q   <= req_read;
          addr_q <= req_addr;
          data_q <= req_wdata;
          idx    <= '0;
          rdata  <= '0;
          st     <= S_WHI;
        end
        S_WHI: if (ready_in) st <= S_STB;
        S_STB: st <= S_WLO;
        S_WLO: if (!ready_in) begin
          if (rw_q) begin
            tmr <= '0;
            st  <= S_WINT;
          end else if (idx == 2'd2) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + 2'd1;
            st  <= S_WHI;
          end
        end
        S_WINT: begin
          if (!int_n) st <= S_RD;
          else if (tmr == TLAST) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else tmr <= tmr + 1'b1;
        end
        S_RD: begin
          rdata <= bus_in;
          done  <= 1'b1;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_port_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> port_sel == 3'b100);
  assert_strobe_after_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> $past(ready_in));
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> wr_n);
  assert_rd_after_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> $past(!int_n));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !req_ready || done);
  assert_timeout_no_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(int_n) && $past(rd_n));
endmodule

// File: tb/nibble_cmd_host_tb.sv
module nibble_cmd_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_read = 0;
  logic [5:0] req_addr = 0;
  logic [7:0] req_wdata = 0, bus_in = 0;
  logic ready_in = 1, int_n = 1;
  logic req_ready, done, err, bus_oe, wr_n, rd_n;
  logic [7:0] rdata, bus_out;
  logic [2:0] port_sel;

  nibble_cmd_host #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .err(err), .rdata(rdata), .port_sel(port_sel),
    .bus_out(bus_out), .bus_oe(bus_oe), .wr_n(wr_n), .rd_n(rd_n),
    .bus_in(bus_in), .ready_in(ready_in), .int_n(int_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int cfg_lag = 0, cfg_lo = 1, cfg_int = 2;
  logic [7:0] cfg_rdata = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model, advanced on each rising edge
  int mph = 0, midx = 0, mt = 0;
  bit mrw = 0, mdone = 0, merr = 0;
  logic [5:0] maddr = 0;
  logic [7:0] mdata = 0, mrdata = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  function automatic logic [7:0] mbyte();
    if (midx == 0) return {1'b1, mrw, maddr};
    if (midx == 1) return {4'h0, mdata[7:4]};
    return {4'h0, mdata[3:0]};
  endfunction

  always @(posedge clk) begin
    mdone = 0; merr = 0;
    if (!rst_n) begin
      mph = 0; midx = 0; mt = 0; mrdata = 0; mrw = 0; maddr = 0; mdata = 0;
    end else begin
      case (mph)
        0: if (req_valid) begin
             mrw = req_read; maddr = req_addr; mdata = req_wdata;
             mrdata = 0; midx = 0; mph = 1;
             exp_q.delete();
             exp_q.push_back({1'b1, req_read, req_addr});
             if (!req_read) begin
               exp_q.push_back({4'h0, req_wdata[7:4]});
               exp_q.push_back({4'h0, req_wdata[3:0]});
             end
           end
        1: if (ready_in) mph = 2;
        2: mph = 3;
        3: if (!ready_in) begin
             if (mrw) begin mph = 4; mt = 0; end
             else if (midx == 2) begin mph = 0; mdone = 1; end
             else begin midx++; mph = 1; end
           end
        4: if (!int_n) mph = 5;
           else if (mt == TO - 1) begin mph = 0; mdone = 1; merr = 1; end
           else mt++;
        5: begin mrdata = bus_in; mph = 0; mdone = 1; end
        default: mph = 0;
      endcase
    end
  end

  // peripheral and per-cycle comparison
  int plag = 0, plo = 0, iwait = -1;
  bit pwait = 0;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog R7 actual=no-completion expected=completion");
      summary();
    end
    if (!rst_n) begin
      check(wr_n && rd_n && !bus_oe && port_sel == 0 && !done && !err && req_ready,
            "R11 reset outputs", {wr_n, rd_n, bus_oe, port_sel, done, err, req_ready}, 9'b110000001);
    end else begin
      check(port_sel == ((mph == 0) ? 3'b000 : 3'b100), "R1 port_sel", port_sel, (mph == 0) ? 0 : 4);
      check(wr_n == (mph != 2), "R2/R5 wr_n strobe timing", wr_n, mph != 2);
      check(bus_oe == (mph == 2), "R2 bus_oe", bus_oe, mph == 2);
      if (mph == 2) check(bus_out == mbyte(), "R3/R4 byte value", bus_out, mbyte());
      check(rd_n == (mph != 5), "R6 rd_n strobe", rd_n, mph != 5);
      check(done == mdone, "R7 done pulse", done, mdone);
      check(err == merr, "R9/R10 err flag", err, merr);
      check(rdata == mrdata, "R6/R7 rdata", rdata, mrdata);
      check(req_ready == (mph == 0), "R8 req_ready", req_ready, mph == 0);
      if (done) begin
        check(got_q.size() == exp_q.size(), "R4 byte count", got_q.size(), exp_q.size());
        foreach (exp_q[i])
          if (i < got_q.size())
            check(got_q[i] == exp_q[i], (i == 0) ? "R3 address byte" : "R4 data nibble byte",
                  got_q[i], exp_q[i]);
        got_q.delete();
        if (err) begin iwait = -1; int_n = 1; end
      end
    end
    // peripheral response
    if (!wr_n) begin
      got_q.push_back(bus_out);
      plag = cfg_lag; pwait = 1;
      if (bus_out[7:6] == 2'b11) iwait = cfg_int;
    end else if (pwait) begin
      if (plag > 0) plag--;
      else begin ready_in = 0; plo = cfg_lo; pwait = 0; end
    end else if (plo > 0) begin
      plo--;
      if (plo == 0) ready_in = 1;
    end
    if (!rd_n) int_n = 1;
    else if (iwait > 0) iwait--;
    else if (iwait == 0) begin int_n = 0; iwait = -1; end
    bus_in = cfg_rdata;
  end

  bit last_err;
  logic [7:0] last_rdata;
  task automatic do_req(input bit rd, input logic [5:0] a, input logic [7:0] d, input int hold);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_read = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (hold > 0) begin
      req_read = !rd; req_addr = ~a; req_wdata = ~d;
      repeat (hold) @(negedge clk);
    end
    req_valid = 0;
    while (!done) @(negedge clk);
    last_err = err; last_rdata = rdata;
  endtask

  initial begin
    bit sweep_ok[int];
    bit edge_seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 basic write
    cfg_lag = 0; cfg_lo = 2;
    do_req(0, 6'h01, 8'hB0, 0);
    check(!last_err, "R7 write err", last_err, 0);
    // R6 read with interrupt
    cfg_rdata = 8'h5A; cfg_int = 3;
    do_req(1, 6'h3F, 8'h00, 0);
    check(last_rdata == 8'h5A && !last_err, "R6 read data", last_rdata, 8'h5A);
    // R5 stale READY kept high after strobes
    cfg_lag = 4; cfg_lo = 1;
    do_req(0, 6'h2A, 8'hC3, 0);
    // R8 request fields change while busy; back to back with next
    cfg_lag = 1; cfg_lo = 3;
    do_req(0, 6'h15, 8'h96, 3);
    cfg_rdata = 8'hE7; cfg_int = 0;
    do_req(1, 6'h00, 8'hFF, 2);
    check(last_rdata == 8'hE7, "R8 read kept original request", last_rdata, 8'hE7);
    // R9 timeout with no interrupt
    cfg_int = -1;
    do_req(1, 6'h11, 8'h00, 0);
    check(last_err && last_rdata == 0, "R9 timeout err", {last_err, last_rdata}, 9'h100);
    // R10 sweep interrupt delay across end of window
    cfg_lag = 0; cfg_lo = 1; cfg_rdata = 8'h3C;
    for (int dly = TO - 4; dly <= TO + 6; dly++) begin
      cfg_int = dly;
      do_req(1, 6'h07, 8'h00, 0);
      sweep_ok[dly] = !last_err;
      repeat (2) @(negedge clk);
    end
    edge_seen = 0;
    for (int dly = TO - 4; dly < TO + 6; dly++)
      if (sweep_ok[dly] && !sweep_ok[dly + 1]) edge_seen = 1;
    check(edge_seen, "R10 boundary success then timeout", edge_seen, 1);
    check(sweep_ok[TO - 4] && !sweep_ok[TO + 6], "R9/R10 sweep ends", {sweep_ok[TO - 4], sweep_ok[TO + 6]}, 2'b10);
    // final write after errors
    cfg_int = 2;
    do_req(0, 6'h3E, 8'h0F, 0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule